// File: doc/BRIEF.md
# Fast-to-Slow Asynchronous Bus Cycle Bridge

This block lets a processor core clocked much faster than a legacy 16-bit asynchronous bus perform single transfers on that bus. The slow bus is paced by a free-running reference clock of about 7 MHz. Each of its cycles is divided into eight half-clock phases, S0 to S7, plus inserted wait phases. The bridge synchronizes the reference into the fast clock domain and turns each of its edges into a one-cycle advance enable. Every strobe transition, every acknowledge sample and every data capture is therefore placed on the slow phase grid, not on the fast clock.

The fast side holds `req` high with a stable address, direction, byte enables and write data. The bridge answers with a single-cycle `done` pulse, and for reads it returns the captured data alongside that pulse. Another master on the slow bus may ask for the bus with an active-low request. The bridge grants it only between its own cycles. While the grant is held, the bridge takes its drivers off the bus and keeps any fast-side request waiting.

Top module: `busbridge_68k`

## Requirements
- R1: The phase sequence advances exactly one phase per reference half-period, and a cycle begins (S0) only on a rising reference edge while the bridge is idle. The address strobe is therefore low for (5 + 2w) reference half-periods, where w is the number of wait pairs.
- R2: `bus_as_n` falls at the start of S2, two reference half-periods after the cycle began.
- R3: On a read, the data strobes fall in the same fast cycle as `bus_as_n`. `req_be[1]` selects `bus_uds_n` (upper byte, data bits 15:8) and `req_be[0]` selects `bus_lds_n` (lower byte, data bits 7:0).
- R4: On a write, `bus_rw` is 0 and the selected data strobes fall two reference half-periods after `bus_as_n`, at the start of S4.
- R5: Acknowledge (`bus_dtack_n`) is sampled only at the end of S4. If it is high, one wait pair (a wait phase, then S4 again) is inserted, and the acknowledge is sampled again at the end of each repeated S4.
- R6: Read data on `bus_din` is captured only at the S6-to-S7 transition and is presented on `rdata` with `done`.
- R7: Address, `bus_rw` (1 = read) and write data are driven from S1 and stay unchanged for as long as `bus_as_n` is low.
- R8: All strobes are high in S7. `done` is a single fast-cycle pulse issued when S7 ends.
- R9: A request on `bus_br_n` (active low) is answered, on a reference edge, by `bus_bg_n` low only while no cycle is in progress. While the grant is held, `bus_oe` is 0.
- R10: A fast-side request raised during a grant starts no cycle until the grant is withdrawn, and then completes normally.
- R11: After reset `bus_as_n`, `bus_uds_n`, `bus_lds_n` and `bus_bg_n` are 1, `bus_rw` is 1, `bus_oe` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, held until `done` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (23) | Word address |
| req_be | input | DW/8 (2) | Byte enables, bit 1 upper, bit 0 lower |
| req_wdata | input | DW (16) | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW (16) | Captured read data |
| ref_clk | input | 1 | Asynchronous slow reference clock |
| bus_addr | output | AW (23) | Slow-bus address |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_dout | output | DW (16) | Write data to the slow bus |
| bus_din | input | DW (16) | Read data from the slow bus |
| bus_dtack_n | input | 1 | Transfer acknowledge, active low, asynchronous |
| bus_oe | output | 1 | Output enable for the bridge's bus drivers |
| bus_br_n | input | 1 | Bus request from another master, active low |
| bus_bg_n | output | 1 | Bus grant, active low |

## Verification
Some properties are checked on every cycle. These are the phase of the cycle at which the address strobe and the write data strobes fall, and the tie between the read data strobes and the address strobe. Also checked are that S5 is reached only after an acknowledge was sampled, and that a wait phase follows only a missing acknowledge. The remaining per-cycle checks cover held address and direction, read data changing only on entry to S7, the one-cycle `done` pulse, and that a grant is held only while idle, with the drivers disabled. Other behaviour can only be shown by the bench's scenarios. That covers the exact strobe widths in fast cycles for several acknowledge latencies, the byte-lane selection, the returned data values, and a request that stays blocked by a grant and then completes after release. It also covers a request from another master that arrives mid-cycle and is deferred until `done`.

// File: rtl/busbridge_pkg.sv
package busbridge_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_S0, PH_S1, PH_S2, PH_S3, PH_S4, PH_S5, PH_S6, PH_S7, PH_SW
  } phase_e;

  // address strobe window: S2 through S6, including wait phases
  function automatic logic as_on(input phase_e p);
    return p inside {PH_S2, PH_S3, PH_S4, PH_S5, PH_S6, PH_SW};
  endfunction

  // data strobe window: reads follow the address strobe, writes start at S4
  function automatic logic ds_on(input phase_e p, input logic rd);
    if (rd) return as_on(p);
    return p inside {PH_S4, PH_S5, PH_S6, PH_SW};
  endfunction

  // address, direction and write data are owned from S1 through S7
  function automatic logic addr_on(input phase_e p);
    return p inside {PH_S1, PH_S2, PH_S3, PH_S4, PH_S5, PH_S6, PH_S7, PH_SW};
  endfunction

  function automatic phase_e phase_after(input phase_e p, input logic go,
                                         input logic ack);
    case (p)
      PH_IDLE: return go ? PH_S0 : PH_IDLE;
      PH_S0:   return PH_S1;
      PH_S1:   return PH_S2;
      PH_S2:   return PH_S3;
      PH_S3:   return PH_S4;
      PH_S4:   return ack ? PH_S5 : PH_SW;
      PH_SW:   return PH_S4;
      PH_S5:   return PH_S6;
      PH_S6:   return PH_S7;
      default: return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/bb_sync.sv
module bb_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/bb_edge.sv
module bb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/bb_arbiter.sv
module bb_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic br_req,
  input  logic idle,
  output logic granted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      granted <= 1'b0;
    end else if (adv) begin
      if (!granted && idle && br_req) granted <= 1'b1;
      else if (granted && !br_req)    granted <= 1'b0;
    end
  end
endmodule

// File: rtl/bb_sequencer.sv
module bb_sequencer
  import busbridge_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16,
  localparam int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          adv,
  input  logic          granted,
  input  logic          br_req,
  input  logic          dtack_q,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_din,
  output phase_e        phase,
  output logic          idle,
  output logic          start,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          as_n,
  output logic          uds_n,
  output logic          lds_n,
  output logic          rw,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dout
);
  phase_e        nx;
  logic          we_q;
  logic [BW-1:0] be_q;
  logic          rd_nx;

  assign idle  = (phase == PH_IDLE);
  assign start = rise && idle && req && !granted && !br_req;
  assign nx    = phase_after(phase, start, dtack_q);
  assign rd_nx = start ? ~req_we : ~we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      we_q  <= 1'b0;
      be_q  <= '0;
      as_n  <= 1'b1;
      uds_n <= 1'b1;
      lds_n <= 1'b1;
      rw    <= 1'b1;
      addr  <= '0;
      dout  <= '0;
    end else if (adv) begin
      phase <= nx;
      if (start) begin
        we_q <= req_we;
        be_q <= req_be;
      end
      if (nx == PH_S1) begin
        addr <= req_addr;
        dout <= req_wdata;
      end
      as_n  <= ~as_on(nx);
      uds_n <= ~(ds_on(nx, rd_nx) && be_q[BW-1]);
      lds_n <= ~(ds_on(nx, rd_nx) && be_q[0]);
      rw    <= addr_on(nx) ? rd_nx : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= adv && (phase == PH_S7);
      if (adv && (phase == PH_S6) && !we_q) rdata <= bus_din;
    end
  end
endmodule

// File: rtl/busbridge_68k.sv
module busbridge_68k
  import busbridge_pkg::*;
#(
  parameter int AW      = 23,
  parameter int DW      = 16,
  parameter int SYNC_ST = 2,
  localparam int BW     = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ref_clk,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  output logic          bus_as_n,
  output logic          bus_uds_n,
  output logic          bus_lds_n,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_dtack_n,
  output logic          bus_oe,
  input  logic          bus_br_n,
  output logic          bus_bg_n
);
  logic   ref_s, dtack_n_s, br_n_s;
  logic   ref_rise, ref_fall, adv;
  logic   dtack_q, br_req, granted, idle, seq_start;
  phase_e phase;

  bb_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b0)) u_sync_ref (
    .clk(clk), .rst_n(rst_n), .d(ref_clk), .q(ref_s));
  bb_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b1)) u_sync_ack (
    .clk(clk), .rst_n(rst_n), .d(bus_dtack_n), .q(dtack_n_s));
  bb_sync #(.STAGES(SYNC_ST), .RST_VAL(1'b1)) u_sync_br (
    .clk(clk), .rst_n(rst_n), .d(bus_br_n), .q(br_n_s));

  bb_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ref_s), .rise(ref_rise), .fall(ref_fall));

  assign adv     = ref_rise | ref_fall;
  assign dtack_q = ~dtack_n_s;
  assign br_req  = ~br_n_s;

  bb_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .adv(adv), .br_req(br_req), .idle(idle),
    .granted(granted));

  bb_sequencer #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .rise(ref_rise), .adv(adv), .granted(granted),
    .br_req(br_req), .dtack_q(dtack_q), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .bus_din(bus_din), .phase(phase), .idle(idle), .start(seq_start),
    .done(done), .rdata(rdata), .as_n(bus_as_n), .uds_n(bus_uds_n),
    .lds_n(bus_lds_n), .rw(bus_rw), .addr(bus_addr), .dout(bus_dout));

  assign bus_oe   = ~granted;
  assign bus_bg_n = ~granted;
endmodule

// File: rtl/bb_checker.sv
module bb_checker
  import busbridge_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adv,
  input logic          start,
  input phase_e        phase,
  input logic          dtack_q,
  input logic          done,
  input logic [DW-1:0] rdata,
  input logic          as_n,
  input logic          uds_n,
  input logic          lds_n,
  input logic          rw,
  input logic [AW-1:0] addr,
  input logic          bg_n,
  input logic          oe
);
  // reference edges counted since the cycle entered S0
  logic [3:0] edge_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       edge_cnt <= 4'd0;
    else if (start)                   edge_cnt <= 4'd0;
    else if (adv && edge_cnt != 4'hF) edge_cnt <= edge_cnt + 4'd1;
  end

  p_as_at_s2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) |-> (edge_cnt == 4'd2));

  p_rd_ds_with_as_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rw && $fell(uds_n && lds_n)) |-> $fell(as_n));

  p_wr_ds_at_s4_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rw && $fell(uds_n && lds_n)) |-> (edge_cnt == 4'd4));

  p_ack_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_S5 && $past(phase) == PH_S4) |-> $past(dtack_q));

  p_wait_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SW && $past(phase) == PH_S4) |-> !$past(dtack_q));

  p_rdata_at_s7_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> (phase == PH_S7));

  p_hold_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !$past(as_n)) |-> ($stable(addr) && $stable(rw)));

  p_s7_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_S7) |-> (as_n && uds_n && lds_n));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_s7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == PH_S7));

  p_grant_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bg_n |-> (phase == PH_IDLE && !oe));

  p_no_start_granted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> bg_n);
endmodule

bind busbridge_68k bb_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .start(seq_start), .phase(phase),
  .dtack_q(dtack_q), .done(done), .rdata(rdata), .as_n(bus_as_n),
  .uds_n(bus_uds_n), .lds_n(bus_lds_n), .rw(bus_rw), .addr(bus_addr),
  .bg_n(bus_bg_n), .oe(bus_oe));

// File: tb/sim_busbridge_68k.sv
module sim_busbridge_68k;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int H  = 12;   // fast cycles per reference half-period

  // {we, addr[22:0], be[1:0], wdata[15:0], lat[3:0], rdata[15:0]}
  localparam int NV = 6;
  localparam logic [61:0] VEC [NV] = '{
    {1'b0, 23'h000400, 2'b11, 16'h0000, 4'd1, 16'hA55A},
    {1'b0, 23'h7FFFFF, 2'b10, 16'h0000, 4'd3, 16'h1234},
    {1'b1, 23'h012345, 2'b11, 16'hBEEF, 4'd1, 16'h0000},
    {1'b1, 23'h400001, 2'b01, 16'h00C3, 4'd2, 16'h0000},
    {1'b0, 23'h000001, 2'b01, 16'h0000, 4'd2, 16'h8001},
    {1'b1, 23'h2AAAAA, 2'b10, 16'hF00F, 4'd4, 16'h0000}
  };

  logic          clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic          req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic          bus_dtack_n = 1'b1, bus_br_n = 1'b1;
  logic          done, bus_rw, bus_as_n, bus_uds_n, bus_lds_n, bus_oe, bus_bg_n;
  logic [DW-1:0] rdata, bus_dout;
  logic [AW-1:0] bus_addr;

  busbridge_68k u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .ref_clk(ref_clk), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_dtack_n(bus_dtack_n),
    .bus_oe(bus_oe), .bus_br_n(bus_br_n), .bus_bg_n(bus_bg_n));

  initial forever #2 clk = ~clk;
  initial begin #1; forever #48 ref_clk = ~ref_clk; end

  int checks = 0, errs = 0, cyc = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // slow-bus slave model and measurements, sampled on the falling clock
  int            lat_cur = 1;
  int            as_fall_cyc = 0, ds_fall_cyc = -1, as_low_cnt = 0, ref_rises = 0;
  logic [AW-1:0] seen_addr = '0;
  logic          seen_rw = 1'b1, moved = 1'b0;
  logic [DW-1:0] seen_dout = '0;
  logic [1:0]    ds_seen = '0;
  logic          prev_as = 1'b1, prev_ref = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (prev_as && !bus_as_n) begin
      as_fall_cyc = cyc; seen_addr = bus_addr; seen_rw = bus_rw;
      seen_dout = bus_dout; moved = 1'b0; as_low_cnt = 0; ref_rises = 0;
      ds_seen = 2'b00; ds_fall_cyc = -1;
    end
    if (!bus_as_n) begin
      as_low_cnt++;
      if (bus_addr != seen_addr || bus_rw != seen_rw || bus_dout != seen_dout)
        moved = 1'b1;
      ds_seen = ds_seen | ~{bus_uds_n, bus_lds_n};
      if (ds_fall_cyc < 0 && (!bus_uds_n || !bus_lds_n)) ds_fall_cyc = cyc;
      if (ref_clk && !prev_ref) ref_rises++;
      bus_dtack_n = (ref_rises >= lat_cur) ? 1'b0 : 1'b1;
    end else begin
      bus_dtack_n = 1'b1;
    end
    prev_as  = bus_as_n;
    prev_ref = ref_clk;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [1:0] be,
                       input logic [DW-1:0] wd, input int lat, input logic [DW-1:0] rd);
    @(negedge clk);
    req_we = we; req_addr = a; req_be = be; req_wdata = wd;
    lat_cur = lat; bus_din = rd; req = 1'b1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
    req = 1'b0;
  endtask

  bit ok;

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(bus_as_n && bus_uds_n && bus_lds_n, "R11 strobes", {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
    chk(bus_bg_n && bus_oe && bus_rw && !done, "R11 misc", {bus_bg_n, bus_oe, bus_rw, done}, 4'b1110);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(bus_as_n && done == 1'b0, "R11 idle after reset", {bus_as_n, done}, 2'b10);

    // vector table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic          we;
      logic [AW-1:0] a;
      logic [1:0]    be;
      logic [DW-1:0] wd, rd;
      int            lat;
      we  = VEC[i][61];
      a   = VEC[i][60:38];
      be  = VEC[i][37:36];
      wd  = VEC[i][35:20];
      lat = int'(VEC[i][19:16]);
      rd  = VEC[i][15:0];
      issue(we, a, be, wd, lat, rd);
      wait_done(ok);
      chk(ok, "R8 done seen", ok, 1);
      if (!we) chk(rdata == rd, "R6 read data", rdata, rd);
      chk(seen_addr == a, "R7 address", seen_addr, a);
      chk(seen_rw == ~we, "R7 direction", seen_rw, ~we);
      if (we) chk(seen_dout == wd, "R7 write data", seen_dout, wd);
      chk(!moved, "R7 held while strobed", moved, 0);
      chk(as_low_cnt == (5 + 2 * (lat - 1)) * H, "R1 R5 strobe width", as_low_cnt, (5 + 2 * (lat - 1)) * H);
      if (we) chk(ds_fall_cyc - as_fall_cyc == 2 * H, "R4 write strobe delay", ds_fall_cyc - as_fall_cyc, 2 * H);
      else    chk(ds_fall_cyc == as_fall_cyc, "R3 read strobe with AS", ds_fall_cyc - as_fall_cyc, 0);
      chk(ds_seen == be, "R3 R4 byte lanes", ds_seen, be);
      @(negedge clk);
      chk(!done && bus_as_n, "R8 single done pulse", {done, bus_as_n}, 2'b01);
      repeat (7) @(negedge clk);
    end

    // R2: AS falls two half-periods after S0; S0 begins after a rising ref edge
    issue(1'b0, 23'h000010, 2'b11, 16'h0, 1, 16'h5A5A);
    wait_done(ok);
    chk(ok && rdata == 16'h5A5A, "R2 short read", rdata, 16'h5A5A);
    repeat (5) @(negedge clk);

    // R9 R10: grant while idle, request blocked until release
    bus_br_n = 1'b0;
    repeat (40) @(negedge clk);
    chk(!bus_bg_n, "R9 grant while idle", bus_bg_n, 0);
    chk(!bus_oe, "R9 drivers off while granted", bus_oe, 0);
    issue(1'b0, 23'h0ABCDE, 2'b11, 16'h0, 1, 16'h6789);
    begin
      bit as_seen = 1'b0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (!bus_as_n || done) as_seen = 1'b1;
      end
      chk(!as_seen, "R10 request held during grant", as_seen, 0);
    end
    bus_br_n = 1'b1;
    wait_done(ok);
    chk(ok && rdata == 16'h6789, "R10 request runs after release", rdata, 16'h6789);
    chk(bus_bg_n && bus_oe, "R9 grant withdrawn", {bus_bg_n, bus_oe}, 2'b11);
    repeat (5) @(negedge clk);

    // R9: request arriving mid-cycle waits for the cycle to end
    issue(1'b1, 23'h001234, 2'b11, 16'h4321, 3, 16'h0);
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (!bus_as_n) break;
    end
    bus_br_n = 1'b0;
    begin
      bit early = 1'b0;
      ok = 1'b0;
      for (int k = 0; k < 3000; k++) begin
        @(negedge clk);
        if (done) begin ok = 1'b1; break; end
        if (!bus_bg_n) early = 1'b1;
      end
      req = 1'b0;
      chk(ok && !early, "R9 no grant mid-cycle", early, 0);
    end
    repeat (40) @(negedge clk);
    chk(!bus_bg_n, "R9 grant after cycle", bus_bg_n, 0);
    bus_br_n = 1'b1;
    repeat (40) @(negedge clk);
    chk(bus_bg_n && bus_oe, "R9 release", {bus_bg_n, bus_oe}, 2'b11);

    finish_run();
  end
endmodule